// File: doc/BRIEF.md
# Privileged Trap Return Unit

This unit carries out the two privileged trap-return operations of a RISC-V style core: the supervisor return and the machine return. The hypervisor extension is optional. The pipeline raises a one-cycle request that names the return it wants. Alongside the request it presents the current privilege, the virtualization flag, the machine and hypervisor status words, both saved exception PCs and three feature straps: compressed instructions, hypervisor, and physical memory protection. A fourth input gives the count of programmed protection rules.

The unit checks the request against a fixed ladder of faults and reports only the first one that applies. If none applies, it commits the updated status words, the target privilege, the target virtualization flag and the return PC into output registers. It also raises a one-cycle strobe that tells the surrounding logic to exchange the guest and host register banks. On a fault it reports an exception cause and keeps every committed value as it was.

The status words keep their architectural bit positions, because the CSR file decodes them. In the machine status word these are: SIE bit 1, MIE bit 3, SPIE bit 5, MPIE bit 7, SPP bit 8, MPP bits 12:11, TSR bit 22 and MPV bit 39. In the hypervisor status word, SPV is bit 7 and VTSR is bit 22.

Top module: `trapret_unit`

## Requirements
- R1: After reset, priv_out is 3 (machine), virt_out is 0, mstatus_out, hstatus_out and ret_pc are 0, and done, fault and swap_pulse are low.
- R2: A supervisor return (req_kind 0) issued with cur_priv 0 (user) faults with fault_code 2 (illegal instruction).
- R3: When cfg_has_c is 0, a return whose selected saved PC (sepc_in for req_kind 0, mepc_in for req_kind 1) has nonzero bits 1:0 faults with fault_code 0 (misaligned fetch). When cfg_has_c is 1, those bits cause no fault.
- R4: A supervisor return with mstatus bit 22 set faults with fault_code 2 when cur_priv is not 3. At cur_priv 3 the bit has no effect.
- R5: A supervisor return with cfg_has_h 1, cur_virt 1 and hstatus bit 22 set faults with fault_code 22 (virtual instruction).
- R6: A legal supervisor return copies mstatus bit 5 into bit 1, sets bit 5, clears bit 8 and sets priv_out to {0, old bit 8}. The return PC is sepc_in.
- R7: A legal supervisor return with cfg_has_h 1 and cur_virt 0 sets virt_out to hstatus bit 7, clears that bit in hstatus_out, and pulses swap_pulse when that bit was 1. Otherwise virt_out keeps cur_virt and hstatus_out equals hstatus_in.
- R8: A machine return (req_kind 1) with cur_priv other than 3 faults with fault_code 2.
- R9: A machine return with cfg_has_pmp 1 and pmp_rule_count 0 faults with fault_code 2 when mstatus bits 12:11 are not 3.
- R10: A legal machine return copies mstatus bit 7 into bit 3, sets bit 7, clears bits 12:11 and bit 39, and sets priv_out to the old bits 12:11. The return PC is mepc_in.
- R11: A legal machine return with cfg_has_h 1 sets virt_out to the old mstatus bit 39 and pulses swap_pulse when that bit was 1. Without the hypervisor strap, virt_out keeps cur_virt.
- R12: Faults are ranked as follows. For the supervisor return: privilege, then alignment, then bit 22, then the virtual check. For the machine return: privilege, then alignment, then the protection rule. Only the highest-ranked fault is reported.
- R13: done or fault rises for exactly the cycle after a request. With no request, or on a fault, the registered outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle return request |
| req_kind | input | 1 | 0 supervisor return, 1 machine return |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| cur_virt | input | 1 | Current virtualization flag |
| mstatus_in | input | 64 | Machine status word |
| hstatus_in | input | 64 | Hypervisor status word |
| sepc_in | input | XLEN | Supervisor saved PC |
| mepc_in | input | XLEN | Machine saved PC |
| cfg_has_c | input | 1 | Compressed instructions present |
| cfg_has_h | input | 1 | Hypervisor extension present |
| cfg_has_pmp | input | 1 | Memory protection present |
| pmp_rule_count | input | PMP_CNT_W | Number of programmed protection rules |
| done | output | 1 | Legal return committed |
| fault | output | 1 | Return rejected |
| fault_code | output | 5 | Exception cause when fault is high |
| swap_pulse | output | 1 | Exchange guest and host register banks |
| mstatus_out | output | 64 | Committed machine status |
| hstatus_out | output | 64 | Committed hypervisor status |
| priv_out | output | 2 | Committed privilege |
| virt_out | output | 1 | Committed virtualization flag |
| ret_pc | output | XLEN | Committed return PC |

## Verification
The hardest cases to reach are those where several faults apply at once, such as a user-mode supervisor return that is also misaligned and blocked by bit 22. The bank-swap path is also hard to reach, because it needs the hypervisor strap, virtualization off and the saved virtualization bit set, all at the same time. Directed requests stack these conditions on purpose. The random requests draw full 64-bit status words, so trap and saved-mode bits appear in many combinations. They also bias the protection rule count towards zero, so the machine-return protection check fires often. Each request is compared with a bench model that tracks the committed state over many requests, so a fault that disturbed the state would show up in a later comparison.

// File: rtl/trapret_pkg.sv
package trapret_pkg;

    localparam int STATUS_W = 64;
    localparam int CAUSE_W  = 5;

    // machine status bit positions (decoded by the CSR file)
    localparam int MS_SIE    = 1;
    localparam int MS_MIE    = 3;
    localparam int MS_SPIE   = 5;
    localparam int MS_MPIE   = 7;
    localparam int MS_SPP    = 8;
    localparam int MS_MPP_LO = 11;
    localparam int MS_MPP_HI = 12;
    localparam int MS_TSR    = 22;
    localparam int MS_MPV    = 39;
    // hypervisor status bit positions
    localparam int HS_SPV    = 7;
    localparam int HS_VTSR   = 22;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic {
        RET_SUP = 1'b0,
        RET_MAC = 1'b1
    } ret_kind_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_MISALIGN = 5'd0,
        CAUSE_ILLEGAL  = 5'd2,
        CAUSE_VIRT     = 5'd22
    } cause_e;

    typedef struct packed {
        logic   hit;
        cause_e cause;
    } fault_t;

    typedef struct packed {
        logic [STATUS_W-1:0] mstatus;
        logic [STATUS_W-1:0] hstatus;
        priv_e               priv;
        logic                virt;
        logic                swap;
    } ret_state_t;

    function automatic fault_t mk_fault(input cause_e c);
        fault_t f;
        f.hit   = 1'b1;
        f.cause = c;
        return f;
    endfunction

endpackage

// File: rtl/trapret_check.sv
module trapret_check
    import trapret_pkg::*;
(
    input  ret_kind_e           kind,
    input  priv_e               cur_priv,
    input  logic                cur_virt,
    input  logic [STATUS_W-1:0] mstatus,
    input  logic [STATUS_W-1:0] hstatus,
    input  logic [1:0]          pc_low,
    input  logic                has_c,
    input  logic                has_h,
    input  logic                has_pmp,
    input  logic                pmp_none,
    output fault_t              result
);
    logic misaligned;
    priv_e target_m;

    assign misaligned = !has_c && (pc_low != 2'b00);
    assign target_m   = priv_e'(mstatus[MS_MPP_HI:MS_MPP_LO]);

    always_comb begin
        result = '{hit: 1'b0, cause: CAUSE_MISALIGN};
        if (kind == RET_SUP) begin
            if (cur_priv == PRIV_U)
                result = mk_fault(CAUSE_ILLEGAL);
            else if (misaligned)
                result = mk_fault(CAUSE_MISALIGN);
            else if (mstatus[MS_TSR] && cur_priv != PRIV_M)
                result = mk_fault(CAUSE_ILLEGAL);
            else if (has_h && cur_virt && hstatus[HS_VTSR])
                result = mk_fault(CAUSE_VIRT);
        end else begin
            if (cur_priv != PRIV_M)
                result = mk_fault(CAUSE_ILLEGAL);
            else if (misaligned)
                result = mk_fault(CAUSE_MISALIGN);
            else if (has_pmp && pmp_none && target_m != PRIV_M)
                result = mk_fault(CAUSE_ILLEGAL);
        end
    end
endmodule

// File: rtl/trapret_update.sv
module trapret_update
    import trapret_pkg::*;
(
    input  ret_kind_e           kind,
    input  logic                cur_virt,
    input  logic [STATUS_W-1:0] mstatus,
    input  logic [STATUS_W-1:0] hstatus,
    input  logic                has_h,
    output ret_state_t          next
);
    always_comb begin
        next.mstatus = mstatus;
        next.hstatus = hstatus;
        next.virt    = cur_virt;
        next.swap    = 1'b0;
        if (kind == RET_SUP) begin
            next.priv                 = priv_e'({1'b0, mstatus[MS_SPP]});
            next.mstatus[MS_SIE]      = mstatus[MS_SPIE];
            next.mstatus[MS_SPIE]     = 1'b1;
            next.mstatus[MS_SPP]      = 1'b0;
            if (has_h && !cur_virt) begin
                next.virt             = hstatus[HS_SPV];
                next.swap             = hstatus[HS_SPV];
                next.hstatus[HS_SPV]  = 1'b0;
            end
        end else begin
            next.priv                 = priv_e'(mstatus[MS_MPP_HI:MS_MPP_LO]);
            next.mstatus[MS_MIE]      = mstatus[MS_MPIE];
            next.mstatus[MS_MPIE]     = 1'b1;
            next.mstatus[MS_MPP_HI:MS_MPP_LO] = 2'b00;
            next.mstatus[MS_MPV]      = 1'b0;
            if (has_h) begin
                next.virt             = mstatus[MS_MPV];
                next.swap             = mstatus[MS_MPV];
            end
        end
    end
endmodule

// File: rtl/trapret_unit.sv
module trapret_unit
    import trapret_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int PMP_CNT_W = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_kind,
    input  logic [1:0]           cur_priv,
    input  logic                 cur_virt,
    input  logic [STATUS_W-1:0]  mstatus_in,
    input  logic [STATUS_W-1:0]  hstatus_in,
    input  logic [XLEN-1:0]      sepc_in,
    input  logic [XLEN-1:0]      mepc_in,
    input  logic                 cfg_has_c,
    input  logic                 cfg_has_h,
    input  logic                 cfg_has_pmp,
    input  logic [PMP_CNT_W-1:0] pmp_rule_count,
    output logic                 done,
    output logic                 fault,
    output logic [CAUSE_W-1:0]   fault_code,
    output logic                 swap_pulse,
    output logic [STATUS_W-1:0]  mstatus_out,
    output logic [STATUS_W-1:0]  hstatus_out,
    output logic [1:0]           priv_out,
    output logic                 virt_out,
    output logic [XLEN-1:0]      ret_pc
);
    ret_kind_e       kind;
    logic [XLEN-1:0] sel_pc;
    fault_t          chk;
    ret_state_t      nxt;

    assign kind   = ret_kind_e'(req_kind);
    assign sel_pc = (kind == RET_MAC) ? mepc_in : sepc_in;

    trapret_check u_check (
        .kind     (kind),
        .cur_priv (priv_e'(cur_priv)),
        .cur_virt (cur_virt),
        .mstatus  (mstatus_in),
        .hstatus  (hstatus_in),
        .pc_low   (sel_pc[1:0]),
        .has_c    (cfg_has_c),
        .has_h    (cfg_has_h),
        .has_pmp  (cfg_has_pmp),
        .pmp_none (pmp_rule_count == '0),
        .result   (chk)
    );

    trapret_update u_update (
        .kind     (kind),
        .cur_virt (cur_virt),
        .mstatus  (mstatus_in),
        .hstatus  (hstatus_in),
        .has_h    (cfg_has_h),
        .next     (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done        <= 1'b0;
            fault       <= 1'b0;
            fault_code  <= '0;
            swap_pulse  <= 1'b0;
            mstatus_out <= '0;
            hstatus_out <= '0;
            priv_out    <= PRIV_M;
            virt_out    <= 1'b0;
            ret_pc      <= '0;
        end else begin
            done       <= req_valid && !chk.hit;
            fault      <= req_valid && chk.hit;
            swap_pulse <= req_valid && !chk.hit && nxt.swap;
            if (req_valid && chk.hit)
                fault_code <= chk.cause;
            if (req_valid && !chk.hit) begin
                mstatus_out <= nxt.mstatus;
                hstatus_out <= nxt.hstatus;
                priv_out    <= nxt.priv;
                virt_out    <= nxt.virt;
                ret_pc      <= sel_pc;
            end
        end
    end
endmodule

// File: rtl/trapret_sva.sv
module trapret_sva (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_kind,
    input logic [1:0]  cur_priv,
    input logic        done,
    input logic        fault,
    input logic [4:0]  fault_code,
    input logic        swap_pulse,
    input logic [63:0] mstatus_out,
    input logic [1:0]  priv_out
);
    p_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    p_idle_r13: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !done && !fault);

    p_fault_hold_r13: assert property (@(posedge clk) disable iff (rst)
        fault |-> $stable(mstatus_out) && $stable(priv_out));

    p_sup_low_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_kind && cur_priv == 2'd0 |=> fault && fault_code == 5'd2);

    p_mac_low_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind && cur_priv != 2'd3 |=> fault && fault_code == 5'd2);

    p_sup_upd_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_kind |=> done |-> mstatus_out[5] && !mstatus_out[8]);

    p_mac_upd_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind |=> done |-> mstatus_out[7] && mstatus_out[12:11] == 2'b00 && !mstatus_out[39]);

    p_swap_r7: assert property (@(posedge clk) disable iff (rst)
        swap_pulse |-> done);
endmodule

bind trapret_unit trapret_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .cur_priv    (cur_priv),
    .done        (done),
    .fault       (fault),
    .fault_code  (fault_code),
    .swap_pulse  (swap_pulse),
    .mstatus_out (mstatus_out),
    .priv_out    (priv_out)
);

// File: tb/trapret_unit_test.sv
module trapret_unit_test;
    localparam int XLEN = 64;
    localparam int PW   = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_kind = 1'b0, cur_virt = 1'b0;
    logic [1:0] cur_priv = 2'd3;
    logic [63:0] mstatus_in = '0, hstatus_in = '0;
    logic [XLEN-1:0] sepc_in = '0, mepc_in = '0;
    logic cfg_has_c = 1'b0, cfg_has_h = 1'b0, cfg_has_pmp = 1'b0;
    logic [PW-1:0] pmp_rule_count = '0;
    logic done, fault, swap_pulse, virt_out;
    logic [4:0] fault_code;
    logic [63:0] mstatus_out, hstatus_out;
    logic [1:0] priv_out;
    logic [XLEN-1:0] ret_pc;

    int n_tests = 0, n_fail = 0;

    // bench's expected committed state
    logic [63:0] e_ms = '0, e_hs = '0;
    logic [1:0]  e_priv = 2'd3;
    logic        e_virt = 1'b0;
    logic [XLEN-1:0] e_pc = '0;

    always #10 clk = ~clk;

    trapret_unit #(.XLEN(XLEN), .PMP_CNT_W(PW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .cur_priv(cur_priv), .cur_virt(cur_virt), .mstatus_in(mstatus_in),
        .hstatus_in(hstatus_in), .sepc_in(sepc_in), .mepc_in(mepc_in),
        .cfg_has_c(cfg_has_c), .cfg_has_h(cfg_has_h), .cfg_has_pmp(cfg_has_pmp),
        .pmp_rule_count(pmp_rule_count), .done(done), .fault(fault),
        .fault_code(fault_code), .swap_pulse(swap_pulse), .mstatus_out(mstatus_out),
        .hstatus_out(hstatus_out), .priv_out(priv_out), .virt_out(virt_out),
        .ret_pc(ret_pc)
    );

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        check(tag, {62'd0, e_virt, priv_out, e_pc, mstatus_out, hstatus_out} ^ {62'd0, virt_out ^ e_virt, 2'd0, ret_pc ^ e_pc, 128'd0},
                   {62'd0, e_virt, e_priv, e_pc, e_ms, e_hs});
    endtask

    // independent model of one request: returns expected strobes and updates e_* on success
    task automatic model(input logic k, input logic [1:0] p, input logic v,
                         input logic [63:0] ms, input logic [63:0] hs,
                         input logic [XLEN-1:0] spc, input logic [XLEN-1:0] mpc,
                         input logic c, input logic h, input logic pm, input logic [PW-1:0] cnt,
                         output logic f, output logic [4:0] code, output logic sw, output string tag);
        logic [XLEN-1:0] pc;
        logic [63:0] nms, nhs;
        pc = k ? mpc : spc;
        f = 1'b1; code = 5'd2; sw = 1'b0; nms = ms; nhs = hs;
        if (!k) begin
            if (p == 2'd0) tag = "R2";
            else if (!c && pc[1:0] != 2'b00) begin code = 5'd0; tag = "R3"; end
            else if (ms[22] && p != 2'd3) tag = "R4";
            else if (h && v && hs[22]) begin code = 5'd22; tag = "R5"; end
            else begin
                f = 1'b0; tag = "R6";
                nms[1] = ms[5]; nms[5] = 1'b1; nms[8] = 1'b0;
                e_priv = {1'b0, ms[8]};
                e_virt = v;
                if (h && !v) begin
                    e_virt = hs[7]; sw = hs[7]; nhs[7] = 1'b0; tag = "R7";
                end
            end
        end else begin
            if (p != 2'd3) tag = "R8";
            else if (!c && pc[1:0] != 2'b00) begin code = 5'd0; tag = "R3"; end
            else if (pm && cnt == '0 && ms[12:11] != 2'd3) tag = "R9";
            else begin
                f = 1'b0; tag = "R10";
                nms[3] = ms[7]; nms[7] = 1'b1; nms[12:11] = 2'd0; nms[39] = 1'b0;
                e_priv = ms[12:11];
                e_virt = v;
                if (h) begin e_virt = ms[39]; sw = ms[39]; tag = "R11"; end
            end
        end
        if (!f) begin e_ms = nms; e_hs = nhs; e_pc = pc; end
    endtask

    task automatic do_req(input logic k, input logic [1:0] p, input logic v,
                          input logic [63:0] ms, input logic [63:0] hs,
                          input logic [XLEN-1:0] spc, input logic [XLEN-1:0] mpc,
                          input logic c, input logic h, input logic pm, input logic [PW-1:0] cnt,
                          input string force_tag);
        logic f, sw;
        logic [4:0] code;
        string tag;
        model(k, p, v, ms, hs, spc, mpc, c, h, pm, cnt, f, code, sw, tag);
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; cur_priv = p; cur_virt = v;
        mstatus_in = ms; hstatus_in = hs; sepc_in = spc; mepc_in = mpc;
        cfg_has_c = c; cfg_has_h = h; cfg_has_pmp = pm; pmp_rule_count = cnt;
        @(negedge clk);
        req_valid = 1'b0;
        if (f) check({tag, " strobes"}, {248'd0, done, fault, sw & 1'b0, fault_code}, {248'd0, 1'b0, 1'b1, 1'b0, code});
        else   check({tag, " strobes"}, {248'd0, done, fault, swap_pulse, 5'd0}, {248'd0, 1'b1, 1'b0, sw, 5'd0});
        check_state({tag, " state"});
    endtask

    localparam logic [63:0] TSR  = 64'h1 << 22;
    localparam logic [63:0] SPIE = 64'h1 << 5;
    localparam logic [63:0] SPP  = 64'h1 << 8;
    localparam logic [63:0] MPIE = 64'h1 << 7;
    localparam logic [63:0] MPPM = 64'h3 << 11;
    localparam logic [63:0] MPV  = 64'h1 << 39;
    localparam logic [63:0] SPV  = 64'h1 << 7;

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        check("R1 reset", {62'd0, done, fault, swap_pulse, virt_out, priv_out, ret_pc, mstatus_out, hstatus_out},
                          {62'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 64'd0, 64'd0, 64'd0});
        n_tests--; // counted once as R1 below
        check("R1 reset", {254'd0, priv_out}, {254'd0, 2'd3});

        do_req(1'b0, 2'd0, 1'b0, SPIE, '0, 64'h100, 64'h0, 1'b0, 1'b0, 1'b0, 7'd1, "R2");
        do_req(1'b0, 2'd1, 1'b0, SPIE, '0, 64'h102, 64'h0, 1'b0, 1'b0, 1'b0, 7'd1, "R3");
        do_req(1'b0, 2'd1, 1'b0, SPIE | SPP, '0, 64'h206, 64'h0, 1'b1, 1'b0, 1'b0, 7'd1, "R3");
        do_req(1'b1, 2'd3, 1'b0, MPPM, '0, 64'h0, 64'h301, 1'b0, 1'b0, 1'b0, 7'd1, "R3");
        do_req(1'b0, 2'd1, 1'b0, TSR, '0, 64'h400, 64'h0, 1'b0, 1'b0, 1'b0, 7'd1, "R4");
        do_req(1'b0, 2'd3, 1'b0, TSR | SPP, '0, 64'h404, 64'h0, 1'b0, 1'b0, 1'b0, 7'd1, "R4");
        do_req(1'b0, 2'd1, 1'b1, '0, 64'h1 << 22, 64'h500, 64'h0, 1'b0, 1'b1, 1'b0, 7'd1, "R5");
        do_req(1'b0, 2'd3, 1'b1, SPIE, 64'h1 << 22, 64'h508, 64'h0, 1'b0, 1'b0, 1'b0, 7'd1, "R5");
        do_req(1'b0, 2'd1, 1'b0, 64'h2 | SPP, '0, 64'h600, 64'h0, 1'b0, 1'b0, 1'b0, 7'd1, "R6");
        do_req(1'b0, 2'd3, 1'b0, SPIE | SPP, SPV | 64'h8, 64'h700, 64'h0, 1'b0, 1'b1, 1'b0, 7'd1, "R7");
        do_req(1'b0, 2'd1, 1'b1, SPIE, SPV, 64'h704, 64'h0, 1'b0, 1'b1, 1'b0, 7'd1, "R7");
        do_req(1'b1, 2'd1, 1'b0, MPPM, '0, 64'h0, 64'h800, 1'b0, 1'b0, 1'b0, 7'd1, "R8");
        do_req(1'b1, 2'd3, 1'b0, MPIE, '0, 64'h0, 64'h900, 1'b0, 1'b0, 1'b1, 7'd0, "R9");
        do_req(1'b1, 2'd3, 1'b0, MPPM, '0, 64'h0, 64'h904, 1'b0, 1'b0, 1'b1, 7'd0, "R9");
        do_req(1'b1, 2'd3, 1'b0, MPIE | (64'h1 << 11), '0, 64'h0, 64'h908, 1'b0, 1'b0, 1'b1, 7'd3, "R9");
        do_req(1'b1, 2'd3, 1'b1, MPIE | MPV | (64'h1 << 11), '0, 64'h0, 64'hA00, 1'b0, 1'b0, 1'b0, 7'd1, "R10");
        do_req(1'b1, 2'd3, 1'b0, MPV | MPPM, '0, 64'h0, 64'hB00, 1'b0, 1'b1, 1'b0, 7'd1, "R11");
        do_req(1'b1, 2'd3, 1'b1, MPPM, '0, 64'h0, 64'hB04, 1'b0, 1'b1, 1'b0, 7'd1, "R11");
        do_req(1'b0, 2'd0, 1'b1, TSR, 64'h1 << 22, 64'hC02, 64'h0, 1'b0, 1'b1, 1'b0, 7'd1, "R12");
        do_req(1'b0, 2'd1, 1'b1, TSR, 64'h1 << 22, 64'hC02, 64'h0, 1'b0, 1'b1, 1'b0, 7'd1, "R12");
        do_req(1'b0, 2'd1, 1'b1, TSR, 64'h1 << 22, 64'hC00, 64'h0, 1'b0, 1'b1, 1'b0, 7'd1, "R12");
        do_req(1'b1, 2'd1, 1'b0, '0, '0, 64'h0, 64'hD02, 1'b0, 1'b0, 1'b1, 7'd0, "R12");
        do_req(1'b1, 2'd3, 1'b0, '0, '0, 64'h0, 64'hD02, 1'b0, 1'b0, 1'b1, 7'd0, "R12");

        // R13: idle cycles with changing inputs leave everything still
        mstatus_in = '1; hstatus_in = '1; mepc_in = '1;
        repeat (3) begin
            @(negedge clk);
            check("R13 idle strobes", {253'd0, done, fault, swap_pulse}, 256'd0);
            check_state("R13 idle state");
        end

        for (int i = 0; i < 600; i++) begin
            logic [1:0] pr;
            logic [1:0] sel;
            sel = 2'($urandom % 3);
            pr  = (sel == 2'd2) ? 2'd3 : sel;
            do_req(1'($urandom), pr, 1'($urandom),
                   {$urandom, $urandom}, {$urandom, $urandom},
                   {$urandom, $urandom}, {$urandom, $urandom},
                   1'($urandom), 1'($urandom), 1'($urandom),
                   ($urandom % 2 == 0) ? 7'd0 : 7'($urandom % 5), "");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R13 actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule